// File: doc/BRIEF.md
# Interrupt Event Queue Enqueue Engine

This block turns an interrupt trigger into one 32-bit record written into a circular queue held in system memory. Each trigger carries a source number. The engine looks that number up in a routing table, which gives a validity flag, a mask flag, a target queue number and a 31-bit event tag. The event tag lets software see a stable logical identity for the source. The engine then reads the target queue's descriptor. The descriptor holds a 60-bit base address, a size exponent, an enable flag and a priority. When every check passes, the engine issues a single write request. The record's top bit is the queue's current generation bit and its low 31 bits are the event tag. The record is presented in big-endian byte order.

Once memory accepts the write, the queue's producer index advances. When the index wraps, the generation bit inverts. Software therefore detects fresh records by comparing the top bit with the generation it expects, and no consumer pointer has to be shared. Both tables are loaded through a 64-bit register write port. Triggers are processed one at a time.

Top module: `evq_enqueue_engine`

## Requirements
- R1: After reset, trig_ready_o is 1, mem_req_o is 0 and err_cnt_o is 0. Every routing entry is invalid, so a trigger on any source produces no write.
- R2: A trigger whose routing entry has valid=0, or has masked=1, produces no memory write and does not change err_cnt_o. The routing entry is loaded with cfg_sel_i=0: valid in bit 63, masked in bit 62, queue number in bits 39:32, event tag in bits 30:0.
- R3: A trigger whose queue has enable=0, or has priority 0xFF, produces no memory write and no error count. These fields are loaded with cfg_sel_i=2: priority in bits 7:0, enable in bit 8.
- R4: mem_addr_o equals base + 4*index, truncated to 60 bits. The base is loaded with cfg_sel_i=1: bits 59:32 form base[59:32] and bits 31:0 form base[31:0].
- R5: The record is {gen, tag[30:0]} and is byte-swapped onto mem_data_o. mem_data_o[7:0] carries record bits 31:24 and mem_data_o[31:24] carries record bits 7:0.
- R6: After each error-free write, the index advances modulo 2^(qsize+10). qsize is taken from cfg_data_i[63:60] of a cfg_sel_i=1 write and is clamped to QSIZE_MAX.
- R7: The generation bit inverts exactly when the index wraps to 0.
- R8: A write acknowledged with mem_err_i=1 leaves the index and the generation unchanged and increments err_cnt_o by one.
- R9: A routing entry naming a queue number of NUM_Q or above is dropped without a write and increments err_cnt_o.
- R10: trig_ready_o is 0 from the cycle after acceptance until the trigger is resolved. mem_req_o, mem_addr_o and mem_data_o stay constant until mem_ack_i.
- R11: Any write of a queue's descriptor (cfg_sel_i=1 or 2) resets that queue's index and generation to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_sel_i | input | 2 | 0 route entry, 1 queue base/size, 2 queue control |
| cfg_idx_i | input | 8 | Source or queue number being written |
| cfg_data_i | input | 64 | Table write data |
| trig_valid_i | input | 1 | Trigger present |
| trig_src_i | input | $clog2(NUM_SRC) | Trigger source number |
| trig_ready_o | output | 1 | Engine idle, trigger accepted this cycle |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 60 | Byte address of the record |
| mem_data_o | output | 32 | Record, big-endian lanes |
| mem_ack_i | input | 1 | Write completion |
| mem_err_i | input | 1 | Completion carries an error |
| err_cnt_o | output | ERR_W | Error counter |

## Verification
The situation hardest to reach from the ports is the index wrap. Only there does the generation bit flip and the address return to the base. The bench reaches it by driving more than 1024 back-to-back triggers into a queue of the smallest size. It then repeats the exercise with more than 4096 triggers after programming an oversize exponent, which tests the clamp. Memory errors are injected on chosen acknowledges so that the following write must reuse the same slot. Queue bases that sit near a 32-bit boundary check that the index carry reaches the high address bits.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int ADDR_W = 60;
  localparam int TAG_W  = 31;

  typedef struct packed {
    logic             valid;
    logic             masked;
    logic [7:0]       qnum;
    logic [TAG_W-1:0] tag;
  } route_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [3:0]        qsize;
    logic              enable;
    logic [7:0]        prio;
  } qdesc_t;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_WRITE} st_e;

  localparam logic [1:0] SEL_ROUTE = 2'd0;
  localparam logic [1:0] SEL_QBASE = 2'd1;
  localparam logic [1:0] SEL_QCTL  = 2'd2;
endpackage

// File: rtl/evq_route_table.sv
module evq_route_table
  import evq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       wr_idx_i,
  input  logic [63:0]      wr_data_i,
  input  logic [SRC_W-1:0] rd_src_i,
  output route_t           rd_ent_o
);
  localparam logic [SRC_W:0] NUM_SRC_L = (SRC_W+1)'(NUM_SRC);

  route_t tbl_q [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tbl_q[g] <= '0;
      end else if (we_i && wr_idx_i == 8'(g)) begin
        tbl_q[g].valid  <= wr_data_i[63];
        tbl_q[g].masked <= wr_data_i[62];
        tbl_q[g].qnum   <= wr_data_i[39:32];
        tbl_q[g].tag    <= wr_data_i[30:0];
      end
    end
  end

  always_comb begin
    rd_ent_o = '0;
    if ({1'b0, rd_src_i} < NUM_SRC_L) rd_ent_o = tbl_q[rd_src_i];
  end
endmodule

// File: rtl/evq_queue_table.sv
module evq_queue_table
  import evq_pkg::*;
#(
  parameter int NUM_Q     = 4,
  parameter int Q_W       = 2,
  parameter int QSIZE_MAX = 2,
  parameter int IDX_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic             ctl_we_i,
  input  logic [7:0]       wr_idx_i,
  input  logic [63:0]      wr_data_i,
  input  logic             adv_i,
  input  logic [Q_W-1:0]   adv_sel_i,
  input  logic [Q_W-1:0]   rd_sel_i,
  output qdesc_t           rd_desc_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             rd_gen_o
);
  localparam logic [Q_W:0] NUM_Q_L = (Q_W+1)'(NUM_Q);

  qdesc_t           desc_q [NUM_Q];
  logic [IDX_W-1:0] idx_q  [NUM_Q];
  logic             gen_q  [NUM_Q];

  function automatic logic [IDX_W-1:0] idx_lim(input logic [3:0] qs);
    logic [4:0] eff;
    eff = (qs > 4'(QSIZE_MAX)) ? 5'(QSIZE_MAX) : {1'b0, qs};
    return IDX_W'((64'd1 << (eff + 5'd10)) - 64'd1);
  endfunction

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic hit;
    assign hit = (wr_idx_i == 8'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        desc_q[g] <= '0;
        idx_q[g]  <= '0;
        gen_q[g]  <= 1'b0;
      end else if (base_we_i && hit) begin
        desc_q[g].base  <= {wr_data_i[59:32], wr_data_i[31:0]};
        desc_q[g].qsize <= wr_data_i[63:60];
        idx_q[g]        <= '0;
        gen_q[g]        <= 1'b0;
      end else if (ctl_we_i && hit) begin
        desc_q[g].prio   <= wr_data_i[7:0];
        desc_q[g].enable <= wr_data_i[8];
        idx_q[g]         <= '0;
        gen_q[g]         <= 1'b0;
      end else if (adv_i && adv_sel_i == Q_W'(g)) begin
        if (idx_q[g] == idx_lim(desc_q[g].qsize)) begin
          idx_q[g] <= '0;
          gen_q[g] <= ~gen_q[g];
        end else begin
          idx_q[g] <= idx_q[g] + 1'b1;
        end
      end
    end

    // R6
    idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_q[g] <= idx_lim(desc_q[g].qsize));
    // R7
    gen_flip_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gen_q[g] != $past(gen_q[g])) |-> (idx_q[g] == '0));
  end

  always_comb begin
    rd_desc_o = '0;
    rd_idx_o  = '0;
    rd_gen_o  = 1'b0;
    if ({1'b0, rd_sel_i} < NUM_Q_L) begin
      rd_desc_o = desc_q[rd_sel_i];
      rd_idx_o  = idx_q[rd_sel_i];
      rd_gen_o  = gen_q[rd_sel_i];
    end
  end
endmodule

// File: rtl/evq_entry_fmt.sv
module evq_entry_fmt
  import evq_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              gen_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [31:0]       data_o
);
  logic [31:0] rec;

  assign addr_o = base_i + ADDR_W'({idx_i, 2'b00});
  assign rec    = {gen_i, tag_i};

  // lowest byte lane carries the most significant record byte
  for (genvar b = 0; b < 4; b++) begin : g_swap
    assign data_o[8*b +: 8] = rec[8*(3-b) +: 8];
  end
endmodule

// File: rtl/evq_enqueue_engine.sv
module evq_enqueue_engine
  import evq_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int NUM_Q     = 4,
  parameter int QSIZE_MAX = 2,
  parameter int ERR_W     = 8,
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [7:0]        cfg_idx_i,
  input  logic [63:0]       cfg_data_i,
  input  logic              trig_valid_i,
  input  logic [SRC_W-1:0]  trig_src_i,
  output logic              trig_ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_data_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  output logic [ERR_W-1:0]  err_cnt_o
);
  localparam int Q_W   = $clog2(NUM_Q);
  localparam int IDX_W = QSIZE_MAX + 10;
  localparam logic [8:0] NUM_Q_L = 9'(NUM_Q);

  st_e               state_q;
  logic [SRC_W-1:0]  src_q;
  logic [Q_W-1:0]    qsel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q;
  logic [ERR_W-1:0]  err_q;

  route_t            rte;
  qdesc_t            desc;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_gen;
  logic [ADDR_W-1:0] fmt_addr;
  logic [31:0]       fmt_data;
  logic              q_ok, advance;
  logic [Q_W-1:0]    rd_sel;

  evq_route_table #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) route_i (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i && cfg_sel_i == SEL_ROUTE),
    .wr_idx_i  (cfg_idx_i),
    .wr_data_i (cfg_data_i),
    .rd_src_i  (src_q),
    .rd_ent_o  (rte)
  );

  assign q_ok    = ({1'b0, rte.qnum} < NUM_Q_L);
  assign rd_sel  = rte.qnum[Q_W-1:0];
  assign advance = (state_q == ST_WRITE) && mem_ack_i && !mem_err_i;

  evq_queue_table #(.NUM_Q(NUM_Q), .Q_W(Q_W), .QSIZE_MAX(QSIZE_MAX), .IDX_W(IDX_W)) qtab_i (
    .clk_i, .rst_ni,
    .base_we_i (cfg_we_i && cfg_sel_i == SEL_QBASE),
    .ctl_we_i  (cfg_we_i && cfg_sel_i == SEL_QCTL),
    .wr_idx_i  (cfg_idx_i),
    .wr_data_i (cfg_data_i),
    .adv_i     (advance),
    .adv_sel_i (qsel_q),
    .rd_sel_i  (rd_sel),
    .rd_desc_o (desc),
    .rd_idx_o  (cur_idx),
    .rd_gen_o  (cur_gen)
  );

  evq_entry_fmt #(.IDX_W(IDX_W)) fmt_i (
    .base_i (desc.base),
    .idx_i  (cur_idx),
    .gen_i  (cur_gen),
    .tag_i  (rte.tag),
    .addr_o (fmt_addr),
    .data_o (fmt_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      qsel_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      err_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (trig_valid_i) begin
          src_q   <= trig_src_i;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          state_q <= ST_IDLE;
          if (rte.valid && !rte.masked) begin
            if (!q_ok) begin
              err_q <= err_q + 1'b1;
            end else if (desc.enable && desc.prio != 8'hFF) begin
              addr_q  <= fmt_addr;
              data_q  <= fmt_data;
              qsel_q  <= rd_sel;
              state_q <= ST_WRITE;
            end
          end
        end
        ST_WRITE: if (mem_ack_i) begin
          if (mem_err_i) err_q <= err_q + 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign trig_ready_o = (state_q == ST_IDLE);
  assign mem_req_o    = (state_q == ST_WRITE);
  assign mem_addr_o   = addr_q;
  assign mem_data_o   = data_q;
  assign err_cnt_o    = err_q;

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)));
  // R10
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_valid_i && trig_ready_o) |=> !trig_ready_o);
  // R8
  err_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o != $past(err_cnt_o)) |-> (err_cnt_o == $past(err_cnt_o) + 1'b1));
  // R2
  drop_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EVAL && (!rte.valid || rte.masked)) |=> !mem_req_o);
endmodule

// File: tb/evq_enqueue_engine_tb.sv
module evq_enqueue_engine_tb_top;
  localparam int NS = 8;
  localparam int NQ = 4;
  localparam int QMAX = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_idx = '0;
  logic [63:0] cfg_data = '0;
  logic        trig_valid = 1'b0;
  logic [2:0]  trig_src = '0;
  logic        trig_ready, mem_req, mem_ack = 1'b0, mem_err = 1'b0;
  logic [59:0] mem_addr;
  logic [31:0] mem_data;
  logic [7:0]  err_cnt;

  evq_enqueue_engine #(.NUM_SRC(NS), .NUM_Q(NQ), .QSIZE_MAX(QMAX), .ERR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data), .trig_valid_i(trig_valid),
    .trig_src_i(trig_src), .trig_ready_o(trig_ready), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err), .err_cnt_o(err_cnt)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  bit          r_val [NS];
  bit          r_msk [NS];
  int          r_q   [NS];
  logic [30:0] r_tag [NS];
  logic [59:0] q_base [NQ];
  int          q_qs  [NQ];
  bit          q_en  [NQ];
  int          q_pri [NQ];
  int          q_idx [NQ];
  bit          q_gen [NQ];
  int          exp_err = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input int idx, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 8'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_route(input int s, input bit v, input bit m, input int q, input logic [30:0] t);
    r_val[s] = v; r_msk[s] = m; r_q[s] = q; r_tag[s] = t;
    cfg(2'd0, s, {v, m, 22'd0, 8'(q), 1'b0, t});
  endtask

  task automatic set_qbase(input int q, input logic [59:0] b, input int qs);
    q_base[q] = b; q_qs[q] = qs; q_idx[q] = 0; q_gen[q] = 0;
    cfg(2'd1, q, {4'(qs), b});
  endtask

  task automatic set_qctl(input int q, input bit en, input int pri);
    q_en[q] = en; q_pri[q] = pri; q_idx[q] = 0; q_gen[q] = 0;
    cfg(2'd2, q, {55'd0, en, 8'(pri)});
  endtask

  task automatic trig(input int s, input bit inj);
    bit will, badq, seen;
    int q, ents, dly;
    logic [31:0] rec, expd;
    logic [59:0] expa;
    q     = r_q[s];
    badq  = r_val[s] && !r_msk[s] && q >= NQ;
    will  = r_val[s] && !r_msk[s] && !badq && q_en[q] && q_pri[q] != 255;
    @(negedge clk);
    chk(trig_ready == 1'b1, "R10 ready idle", 64'(trig_ready), 64'd1);
    trig_valid = 1'b1; trig_src = 3'(s);
    @(negedge clk);
    trig_valid = 1'b0;
    chk(trig_ready == 1'b0, "R10 busy after accept", 64'(trig_ready), 64'd0);
    seen = 0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (mem_req) begin seen = 1; break; end
    end
    chk(seen == will, "R2 R3 R9 write expected", 64'(seen), 64'(will));
    if (seen && will) begin
      expa = q_base[q] + 60'(q_idx[q] * 4);
      rec  = {q_gen[q], r_tag[s]};
      expd = {rec[7:0], rec[15:8], rec[23:16], rec[31:24]};
      chk(mem_addr == expa, "R4 address", 64'(mem_addr), 64'(expa));
      chk(mem_data == expd, "R5 R7 record", 64'(mem_data), 64'(expd));
      dly = s % 3;
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk(mem_req && mem_addr == expa, "R10 request held", 64'(mem_addr), 64'(expa));
      end
      mem_ack = 1'b1; mem_err = inj;
      @(negedge clk);
      mem_ack = 1'b0; mem_err = 1'b0;
      if (inj) exp_err++;
      else begin
        ents = 1 << ((q_qs[q] > QMAX ? QMAX : q_qs[q]) + 10);
        q_idx[q] = (q_idx[q] + 1) % ents;
        if (q_idx[q] == 0) q_gen[q] = ~q_gen[q];
      end
    end else if (badq) exp_err++;
    chk(trig_ready == 1'b1 && !mem_req, "R10 back to idle", 64'(trig_ready), 64'd1);
    chk(err_cnt == 8'(exp_err), "R8 R9 error count", 64'(err_cnt), 64'(exp_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin r_val[s] = 0; r_msk[s] = 0; r_q[s] = 0; r_tag[s] = '0; end
    for (int q = 0; q < NQ; q++) begin
      q_base[q] = '0; q_qs[q] = 0; q_en[q] = 0; q_pri[q] = 0; q_idx[q] = 0; q_gen[q] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(trig_ready == 1'b1, "R1 ready", 64'(trig_ready), 64'd1);
    chk(mem_req == 1'b0, "R1 no request", 64'(mem_req), 64'd0);
    chk(err_cnt == 8'd0, "R1 error count", 64'(err_cnt), 64'd0);
    for (int s = 0; s < NS; s++) trig(s, 1'b0);

    set_qbase(0, 60'h0123456_00001000, 0);
    set_qbase(1, 60'hFFFFFFF_00010000, 0);
    set_qbase(2, 60'h0000ABC_FFFFFFF0, 0);
    set_qbase(3, 60'h8000001_40000000, 1);
    for (int q = 0; q < NQ; q++) set_qctl(q, 1'b1, q * 3);
    for (int s = 0; s < NS; s++)
      set_route(s, 1'b1, 1'b0, s % NQ, 31'((s * 32'h13579BDF) ^ 32'h5A5A5A5A));

    // R4 R5 R6 sweep with R8 error injection
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < NS; s++) trig(s, r == 1 && (s == 5 || s == 2));

    // R2 masked and invalid routes
    set_route(6, 1'b1, 1'b1, 2, 31'h1234);
    set_route(7, 1'b0, 1'b0, 3, 31'h5678);
    trig(6, 1'b0); trig(7, 1'b0);
    // R3 queue disabled and priority 0xFF
    set_qctl(3, 1'b0, 5);
    set_qctl(2, 1'b1, 255);
    trig(3, 1'b0); trig(2, 1'b0);
    set_qctl(3, 1'b1, 5);
    set_qctl(2, 1'b1, 7);
    trig(3, 1'b0); trig(2, 1'b0);
    // R9 queue number out of range
    set_route(4, 1'b1, 1'b0, 9, 31'h7FFFFFFF);
    trig(4, 1'b0); trig(4, 1'b0);

    // R11 control rewrite restarts queue 0 at its base
    trig(0, 1'b0);
    set_qctl(0, 1'b1, 1);
    trig(0, 1'b0);
    // R6 R7 wrap of a 1024-entry queue
    for (int i = 0; i < 1030; i++) trig(0, i == 1023);
    // R6 clamp of oversize exponent to 4096 entries
    set_qbase(1, 60'h0000010_00000000, 9);
    for (int i = 0; i < 4100; i++) trig(1, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule